// File: doc/BRIEF.md
# Multicart PRG Banking and RAM-Overlay Mapper

This block sits on the cartridge side of a 6502-style CPU bus and decides, for every access in the $8000-$FFFF window, which 8 KiB page of a 1-2 MiB program ROM is addressed, or whether an 8 KiB RAM answers instead. It also steers the console nametable address line so that mirroring can be vertical or horizontal.

A single configuration register is loaded by a CPU write. The address of that write carries the bank number on CPU A12..A5. The data byte carries the banking mode, the position of the RAM window and the mirroring. Three banking layouts are provided: a switchable 16 KiB page with a fixed page 0 above it, one 8 KiB page repeated four times, and four consecutive 8 KiB pages with optional extra high-page offsets on the last slot. Writes to the top 8 KiB slot never touch the register, so RAM placed there can be written freely.

Top module: `prg_overlay_mapper`

## Requirements
- R1: After reset the register reads as zero: 16 KiB switchable layout with bank 0, RAM at $8000-$9FFF, vertical mirroring.
- R2: A CPU write (cpu_rw low, m2 high) to $8000-$DFFF loads bank[7:0] from cpu_addr[12:5] (cpu_addr[12] into bank[7]) and the mode fields from cpu_data; the new setting applies from the next clock edge.
- R3: A CPU write to $E000-$FFFF leaves the register unchanged, whatever its address and data bits.
- R4: With cpu_data bit 3 = 0 and bit 1 = 0, slot addresses $8000-$BFFF map to prg_addr = {bank[7:1], cpu_addr[13]}, and $C000-$FFFF map to prg_addr = {7'b0, cpu_addr[13]}.
- R5: With bit 3 = 0 and bit 1 = 1, every slot maps to prg_addr = bank[7:0].
- R6: With bit 3 = 1 (bit 1 ignored), slot s (0..3 for $8000, $A000, $C000, $E000) maps to {bank[7:2], s}; for slot 3, prg_addr bit 2 is also set when data bit 2 (L) is 1, and bit 3 is also set when L and data bit 6 (U) are both 1.
- R7: Data bits 5:4 (window W) place the RAM over slot W, where slot 0..3 are $8000, $A000, $C000, $E000.
- R8: Only in the layout of R5 the RAM also covers slot W XOR 2.
- R9: Inside the RAM window ram_sel is high and rom_sel is low; ram_we is high only for a write with m2 high; rom_sel is high only for reads with cpu_addr[15] = 1 outside the window; nothing is selected below $8000.
- R10: Data bit 0 = 1 gives horizontal mirroring (ciram_a10 follows ppu_a11); 0 gives vertical (ciram_a10 follows ppu_a10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (write data) |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| m2 | input | 1 | CPU phase-2 qualifier |
| ppu_a10 | input | 1 | Picture bus address bit 10 |
| ppu_a11 | input | 1 | Picture bus address bit 11 |
| prg_addr | output | 8 | Program ROM address lines A20..A13 |
| rom_sel | output | 1 | Program ROM read enable |
| ram_sel | output | 1 | Overlay RAM chip enable |
| ram_we | output | 1 | Overlay RAM write enable |
| ciram_a10 | output | 1 | Nametable RAM address bit 10 |

## Verification
On every clock the assertions check that ROM and RAM are never enabled together, that the RAM write strobe only appears inside the window during a qualified write, that the RAM covers exactly one slot or two in the repeated-page layout, that a loaded bank equals the captured address bits, that top-slot writes leave the register untouched, and that the fixed upper half of the 16 KiB layout always points at page 0. The exact page numbers per layout and slot, the L/U offsets on the last slot, the secondary RAM slot position and the mirroring choice depend on specific write sequences, so only the bench's vector walk and directed cases show them.

// File: rtl/prg_overlay_pkg.sv
package prg_overlay_pkg;

  localparam int BANK_W = 8;
  localparam int SLOT_W = 2;

  typedef struct packed {
    logic              hi_u;
    logic [SLOT_W-1:0] win;
    logic              quad;
    logic              hi_l;
    logic              rep8;
    logic              horiz;
    logic [BANK_W-1:0] bank;
  } map_cfg_t;

  localparam int CFG_DATA_W = 7;

  function automatic logic rep_mode(map_cfg_t c);
    return c.rep8 && !c.quad;
  endfunction

  function automatic logic [BANK_W-1:0] page_for_slot(map_cfg_t c, logic [SLOT_W-1:0] s);
    logic [BANK_W-1:0] p;
    if (c.quad) begin
      p = {c.bank[BANK_W-1:SLOT_W], s};
      if (s == '1) begin
        p[SLOT_W]   = p[SLOT_W]   | c.hi_l;
        p[SLOT_W+1] = p[SLOT_W+1] | (c.hi_l & c.hi_u);
      end
    end else if (c.rep8) begin
      p = c.bank;
    end else if (s[SLOT_W-1]) begin
      p = {{(BANK_W-1){1'b0}}, s[0]};
    end else begin
      p = {c.bank[BANK_W-1:1], s[0]};
    end
    return p;
  endfunction

  function automatic logic ram_covers(map_cfg_t c, logic [SLOT_W-1:0] s);
    logic [SLOT_W-1:0] alt;
    alt = c.win ^ {1'b1, {(SLOT_W-1){1'b0}}};
    return (s == c.win) || (rep_mode(c) && (s == alt));
  endfunction

endpackage

// File: rtl/map_cfg_latch.sv
module map_cfg_latch
  import prg_overlay_pkg::*;
#(
  parameter int ADDR_LSB = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            a_top,
  input  logic [BANK_W-1:0]     a_bank,
  input  logic [CFG_DATA_W-1:0] d_cfg,
  input  logic                  cpu_rw,
  input  logic                  m2,
  output map_cfg_t              cfg,
  output logic                  load_ev,
  output logic                  skip_ev
);

  logic wr_cycle;
  assign wr_cycle = a_top[2] && !cpu_rw && m2;
  assign skip_ev  = wr_cycle && (a_top[1:0] == 2'b11);
  assign load_ev  = wr_cycle && (a_top[1:0] != 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (load_ev) begin
      cfg.bank  <= a_bank;
      cfg.horiz <= d_cfg[0];
      cfg.rep8  <= d_cfg[1];
      cfg.hi_l  <= d_cfg[2];
      cfg.quad  <= d_cfg[3];
      cfg.win   <= d_cfg[5:4];
      cfg.hi_u  <= d_cfg[6];
    end
  end

  assert_capture_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (cfg.bank == $past(a_bank)));

  assert_top_write_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    skip_ev |=> $stable(cfg));

endmodule

// File: rtl/prg_slot_decode.sv
module prg_slot_decode
  import prg_overlay_pkg::*;
(
  input  map_cfg_t          cfg,
  input  logic [2:0]        a_top,
  input  logic              cpu_rw,
  input  logic              m2,
  output logic [BANK_W-1:0] prg_addr,
  output logic [3:0]        slot_hits,
  output logic              rom_sel,
  output logic              ram_sel,
  output logic              ram_we
);

  logic [SLOT_W-1:0] slot;
  logic              in_win;
  assign slot = a_top[1:0];

  for (genvar g = 0; g < 4; g++) begin : g_hit
    assign slot_hits[g] = ram_covers(cfg, SLOT_W'(g));
  end

  assign in_win   = slot_hits[slot];
  assign prg_addr = page_for_slot(cfg, slot);
  assign ram_sel  = a_top[2] && in_win;
  assign ram_we   = ram_sel && !cpu_rw && m2;
  assign rom_sel  = a_top[2] && cpu_rw && !in_win;

endmodule

// File: rtl/mirror_select.sv
module mirror_select (
  input  logic horiz,
  input  logic ppu_a10,
  input  logic ppu_a11,
  output logic ciram_a10
);

  assign ciram_a10 = horiz ? ppu_a11 : ppu_a10;

endmodule

// File: rtl/prg_overlay_mapper.sv
module prg_overlay_mapper
  import prg_overlay_pkg::*;
#(
  parameter int ADDR_LSB = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        cpu_rw,
  input  logic        m2,
  input  logic        ppu_a10,
  input  logic        ppu_a11,
  output logic [7:0]  prg_addr,
  output logic        rom_sel,
  output logic        ram_sel,
  output logic        ram_we,
  output logic        ciram_a10
);

  map_cfg_t   cfg;
  logic       load_ev;
  logic       skip_ev;
  logic [3:0] slot_hits;
  logic       unused_bits;

  assign unused_bits = ^{cpu_addr[ADDR_LSB-1:0], cpu_data[7]};

  map_cfg_latch #(.ADDR_LSB(ADDR_LSB)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_top   (cpu_addr[15:13]),
    .a_bank  (cpu_addr[ADDR_LSB +: BANK_W]),
    .d_cfg   (cpu_data[CFG_DATA_W-1:0]),
    .cpu_rw  (cpu_rw),
    .m2      (m2),
    .cfg     (cfg),
    .load_ev (load_ev),
    .skip_ev (skip_ev)
  );

  prg_slot_decode u_decode (
    .cfg       (cfg),
    .a_top     (cpu_addr[15:13]),
    .cpu_rw    (cpu_rw),
    .m2        (m2),
    .prg_addr  (prg_addr),
    .slot_hits (slot_hits),
    .rom_sel   (rom_sel),
    .ram_sel   (ram_sel),
    .ram_we    (ram_we)
  );

  mirror_select u_mirror (
    .horiz     (cfg.horiz),
    .ppu_a10   (ppu_a10),
    .ppu_a11   (ppu_a11),
    .ciram_a10 (ciram_a10)
  );

  assert_chip_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel && ram_sel));

  assert_we_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_sel && m2 && !cpu_rw && cpu_addr[15]));

  assert_window_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_hits) == ((cfg.rep8 && !cfg.quad) ? 2 : 1));

  assert_fixed_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.quad && !cfg.rep8 && cpu_addr[15] && cpu_addr[14]) |-> (prg_addr[7:1] == 7'd0));

endmodule

// File: tb/prg_overlay_mapper_test.sv
`timescale 1ns/1ps
module prg_overlay_mapper_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_rw = 1'b1;
  logic        m2 = 1'b0;
  logic        ppu_a10 = 1'b0;
  logic        ppu_a11 = 1'b0;
  logic [7:0]  prg_addr;
  logic        rom_sel, ram_sel, ram_we, ciram_a10;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prg_overlay_mapper uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_rw(cpu_rw), .m2(m2), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11),
    .prg_addr(prg_addr), .rom_sel(rom_sel), .ram_sel(ram_sel),
    .ram_we(ram_we), .ciram_a10(ciram_a10)
  );

  // {write addr, write data, read addr, expected page, expected RAM hit}
  localparam int NV = 25;
  localparam logic [48:0] VEC [NV] = '{
    {16'h94A0, 8'h00, 16'hB000, 8'hA5, 1'b0},  // R4
    {16'h94A0, 8'h00, 16'hC000, 8'h00, 1'b0},  // R4
    {16'h94A0, 8'h00, 16'hE000, 8'h01, 1'b0},  // R4
    {16'h94A0, 8'h00, 16'h8000, 8'hA4, 1'b1},  // R7
    {16'h8780, 8'h02, 16'hA000, 8'h3C, 1'b0},  // R5
    {16'h8780, 8'h02, 16'hE000, 8'h3C, 1'b0},  // R5
    {16'h8780, 8'h02, 16'hC000, 8'h3C, 1'b1},  // R8
    {16'h8780, 8'h32, 16'hA000, 8'h3C, 1'b1},  // R8
    {16'h8780, 8'h32, 16'h8000, 8'h3C, 1'b0},  // R5
    {16'h9E60, 8'h08, 16'hA000, 8'hF1, 1'b0},  // R6
    {16'h9E60, 8'h08, 16'hC000, 8'hF2, 1'b0},  // R6
    {16'h9E60, 8'h08, 16'hE000, 8'hF3, 1'b0},  // R6
    {16'h9E60, 8'h08, 16'h8000, 8'hF0, 1'b1},  // R7
    {16'h9E60, 8'h0C, 16'hE000, 8'hF7, 1'b0},  // R6 L
    {16'h8020, 8'h4C, 16'hE000, 8'h0F, 1'b0},  // R6 L+U
    {16'h8020, 8'h48, 16'hE000, 8'h03, 1'b0},  // R6 U alone
    {16'hC800, 8'h1A, 16'hC000, 8'h42, 1'b0},  // R2 load from $C000 range, R6 bit1 ignored
    {16'hC800, 8'h1A, 16'hE000, 8'h43, 1'b0},  // R8 no second slot
    {16'hC800, 8'h1A, 16'hA000, 8'h41, 1'b1},  // R7
    {16'h8040, 8'h20, 16'hC000, 8'h00, 1'b1},  // R7
    {16'h8040, 8'h20, 16'h8000, 8'h02, 1'b0},  // R4
    {16'h8040, 8'h20, 16'hA000, 8'h03, 1'b0},  // R4
    {16'h8040, 8'h22, 16'h8000, 8'h02, 1'b1},  // R8
    {16'h8040, 8'h22, 16'hC000, 8'h02, 1'b1},  // R8
    {16'h8040, 8'h22, 16'hE000, 8'h02, 1'b0}   // R8
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_rw = 1'b0; m2 = 1'b1;
    @(negedge clk);
    cpu_rw = 1'b1; m2 = 1'b0;
  endtask

  task automatic cpu_read(logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_rw = 1'b1; m2 = 1'b1;
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    cpu_read(16'h8000);
    check("R1 ram at 8000", {15'd0, ram_sel}, 16'd1);
    cpu_read(16'hA000);
    check("R1 page", {8'd0, prg_addr}, 16'h0001);
    cpu_read(16'hC000);
    check("R1 fixed page", {8'd0, prg_addr}, 16'h0000);
    ppu_a10 = 1'b1; ppu_a11 = 1'b0; #1;
    check("R1 vertical", {15'd0, ciram_a10}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      cpu_write(VEC[i][48:33], VEC[i][32:25]);
      cpu_read(VEC[i][24:9]);
      check($sformatf("R2/R4-R8 vec %0d page", i), {8'd0, prg_addr}, {8'd0, VEC[i][8:1]});
      check($sformatf("R7/R8 vec %0d ram", i), {15'd0, ram_sel}, {15'd0, VEC[i][0]});
      check($sformatf("R9 vec %0d rom", i), {15'd0, rom_sel}, {15'd0, ~VEC[i][0]});
    end

    // R3: top-slot write leaves register unchanged; RAM there is writable
    cpu_write(16'h8020, 8'h38);
    @(negedge clk);
    cpu_addr = 16'hFFE0; cpu_data = 8'h01; cpu_rw = 1'b0; m2 = 1'b1;
    #2;
    check("R9 we at E000", {15'd0, ram_we}, 16'd1);
    @(negedge clk);
    cpu_rw = 1'b1; m2 = 1'b0;
    cpu_read(16'hC000);
    check("R3 page unchanged", {8'd0, prg_addr}, 16'h0002);
    cpu_read(16'hE000);
    check("R3 window unchanged", {15'd0, ram_sel}, 16'd1);
    ppu_a10 = 1'b1; ppu_a11 = 1'b0; #1;
    check("R3 mirroring unchanged", {15'd0, ciram_a10}, 16'd1);

    // R9 qualifications
    @(negedge clk);
    cpu_addr = 16'hE000; cpu_rw = 1'b0; m2 = 1'b0; #2;
    check("R9 no we without m2", {15'd0, ram_we}, 16'd0);
    check("R9 sel without m2", {15'd0, ram_sel}, 16'd1);
    @(negedge clk);
    cpu_addr = 16'hC000; cpu_rw = 1'b0; m2 = 1'b1; #2;
    check("R9 no rom on write", {15'd0, rom_sel}, 16'd0);
    check("R9 no we outside window", {15'd0, ram_we}, 16'd0);
    @(negedge clk);
    cpu_rw = 1'b1; m2 = 1'b0;
    cpu_read(16'h6000);
    check("R9 below 8000", {14'd0, rom_sel, ram_sel}, 16'd0);

    // R10 mirroring
    cpu_write(16'h8000, 8'h01);
    @(negedge clk);
    ppu_a10 = 1'b1; ppu_a11 = 1'b0; #1;
    check("R10 horiz a10", {15'd0, ciram_a10}, 16'd0);
    ppu_a10 = 1'b0; ppu_a11 = 1'b1; #1;
    check("R10 horiz a11", {15'd0, ciram_a10}, 16'd1);
    cpu_write(16'h8000, 8'h00);
    @(negedge clk); #1;
    check("R10 vertical", {15'd0, ciram_a10}, 16'd0);

    // R1 again: reset mid-run clears
    cpu_write(16'h9FE0, 8'h7F);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    cpu_read(16'hA000);
    check("R1 after reset page", {8'd0, prg_addr}, 16'h0001);
    check("R1 after reset rom", {15'd0, rom_sel}, 16'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule